// File: doc/BRIEF.md
# Calibrated Temperature Converter with Bank Maximum

This block turns raw thermal-sensor ADC codes into signed temperatures in millidegrees Celsius. It then reports the hottest reading of a bank of up to four sensing points. Each point supplies a raw code and a tag. The tag selects which of five physical sensors produced the code, and so which per-sensor offset applies.

The calibration comes in as three 32-bit words. A set bit 0 in word 0 means the fields in the words are used. A clear bit 0 means built-in defaults apply instead.

A start pulse latches the calibration words, the point count, the raw codes and the tags. The block then runs two sequential restoring divisions to form a shared scale factor. After that it converts one point per cycle and emits each result with a pulse. One cycle after the last point it emits the bank maximum with a pulse of its own.

Readings above 200000 millidegrees are treated as implausible. They are replaced by zero both in the per-point output and before the maximum is taken.

Top module: `thc_temp_bank`

## Requirements
- R1: After a synchronous reset, including one that interrupts a conversion, `temp_vld_o` and `max_vld_o` stay low until the next accepted start, and `temp_o` and `max_o` read zero.
- R2: Only bits [11:0] of each `raw_i` entry take part in the conversion. The upper 20 bits have no effect.
- R3: Each point converts as follows. First, q1 = 1627604160 / (165 + slope), then q = q1 / (10000 + gain); both divisions truncate. Next, t = (q × (raw − offs − 3350)) arithmetically shifted right by 3, in signed 32-bit arithmetic. The result is ref × 500 − t.
- R4: When `cal_w0_i[0]` is 1, the fields come from fixed bit positions. The slope is w0[31:26] and ref is w0[6:1]. The gain is w1[31:22]. Sensor offsets 0 and 1 are w0[25:17] and w0[16:8]. Offset 2 is w1[8:0]. Offsets 3 and 4 are w2[31:23] and w2[22:14].
- R5: When `cal_w0_i[0]` is 0, every other bit of the three words is ignored. The defaults are gain 512, ref 40, slope 0 and 260 for all five offsets.
- R6: Any converted value greater than 200000 is reported as 0 on `temp_o` and enters the maximum as 0.
- R7: `max_o` is the signed maximum over the first `npts_i` points, starting from 0x80000000. A count of 0 yields 0x80000000. Counts above 4 act as 4.
- R8: Points come out in slot order 0,1,2,… on consecutive cycles, one `temp_vld_o` pulse each, with `temp_slot_o` holding the slot. `max_vld_o` pulses exactly once, in the cycle after the last point, or without any point when the count is 0.
- R9: A tag of 0 to 4 selects that sensor's offset. Tags 5 to 7 use the offset 260.
- R10: A start that arrives while a conversion runs is ignored. Changes to any input after an accepted start do not affect that conversion's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion when idle |
| cal_w0_i | input | 32 | Calibration word 0 (bit 0 = fields valid) |
| cal_w1_i | input | 32 | Calibration word 1 |
| cal_w2_i | input | 32 | Calibration word 2 |
| npts_i | input | 3 | Number of points in the bank |
| raw_i | input | 4×32 | Raw code per slot |
| sidx_i | input | 4×3 | Sensor tag per slot |
| temp_o | output | 32 | Converted point temperature, signed mdegC |
| temp_slot_o | output | 2 | Slot of the current `temp_o` |
| temp_vld_o | output | 1 | Pulse: `temp_o` valid |
| max_o | output | 32 | Bank maximum, signed mdegC |
| max_vld_o | output | 1 | Pulse: `max_o` valid |

## Verification
The bound checker watches several properties on every cycle. It confirms that no reported point exceeds the plausibility cap and that the two valid pulses never coincide. It confirms that the maximum pulse lasts a single cycle. It also checks that a maximum is never below the point reported just before it, and that a bank with no point reports the most negative value.

The arithmetic itself can only be shown by the bench's scenarios, which compare results against an independent evaluation of the formula. This covers the truncating divisions and the negative shift, the calibration field positions and the default fallback, out-of-range tags, masking of raw codes, count clamping, and a start or input change while busy.

// File: rtl/thc_pkg.sv
package thc_pkg;

    localparam int DW      = 32;
    localparam int RAW_W   = 12;
    localparam int NUM_TS  = 5;
    localparam int IDX_W   = $clog2(NUM_TS);
    localparam int OFFS_W  = 9;
    localparam int GAIN_W  = 10;
    localparam int REF_W   = 6;
    localparam int SLOPE_W = 6;
    localparam int SHIFT   = 3;

    // scaled numerator: 203450520 * 8
    localparam logic [DW-1:0]        SCALE_NUM  = 32'd1627604160;
    localparam logic [DW-1:0]        SLOPE_BASE = 32'd165;
    localparam logic [DW-1:0]        GAIN_BASE  = 32'd10000;
    localparam logic signed [DW-1:0] CODE_BIAS  = 32'sd3350;
    localparam logic signed [DW-1:0] REF_MULT   = 32'sd500;
    localparam logic signed [DW-1:0] BOGUS_CAP  = 32'sd200000;

    localparam logic [GAIN_W-1:0]  DEF_GAIN  = 10'd512;
    localparam logic [REF_W-1:0]   DEF_REF   = 6'd40;
    localparam logic [SLOPE_W-1:0] DEF_SLOPE = 6'd0;
    localparam logic [OFFS_W-1:0]  DEF_OFFS  = 9'd260;

    typedef struct packed {
        logic [GAIN_W-1:0]              gain;
        logic [REF_W-1:0]               ref_c;
        logic [SLOPE_W-1:0]             slope;
        logic [NUM_TS-1:0][OFFS_W-1:0]  offs;
    } cal_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV_SLOPE,
        ST_DIV_GAIN,
        ST_CONV,
        ST_FIN
    } state_t;

    // extract fields, or fall back to defaults when word 0 bit 0 is clear
    function automatic cal_t unpack_cal(input logic [DW-1:0] w0,
                                        input logic [DW-1:0] w1,
                                        input logic [DW-1:0] w2);
        cal_t c;
        if (w0[0]) begin
            c.slope   = w0[31:26];
            c.ref_c   = w0[6:1];
            c.gain    = w1[31:22];
            c.offs[0] = w0[25:17];
            c.offs[1] = w0[16:8];
            c.offs[2] = w1[8:0];
            c.offs[3] = w2[31:23];
            c.offs[4] = w2[22:14];
        end else begin
            c.slope = DEF_SLOPE;
            c.ref_c = DEF_REF;
            c.gain  = DEF_GAIN;
            for (int i = 0; i < NUM_TS; i++) c.offs[i] = DEF_OFFS;
        end
        return c;
    endfunction

    function automatic logic [RAW_W-1:0] mask_raw(input logic [DW-1:0] r);
        return r[RAW_W-1:0];
    endfunction

    // scale, offset and reference combination for one point
    function automatic logic signed [DW-1:0] to_mdeg(input logic [DW-1:0]    q,
                                                     input logic [RAW_W-1:0] raw,
                                                     input logic [OFFS_W-1:0] offs,
                                                     input logic [REF_W-1:0] ref_c);
        logic signed [DW-1:0] diff;
        logic signed [DW-1:0] prod;
        logic signed [DW-1:0] t;
        logic signed [DW-1:0] base;
        diff = $signed(DW'(raw)) - $signed(DW'(offs)) - CODE_BIAS;
        prod = $signed(q) * diff;
        t    = prod >>> SHIFT;
        base = $signed(DW'(ref_c)) * REF_MULT;
        return base - t;
    endfunction

    function automatic logic signed [DW-1:0] scrub(input logic signed [DW-1:0] v);
        return (v > BOGUS_CAP) ? '0 : v;
    endfunction

endpackage

// File: rtl/thc_rdiv.sv
module thc_rdiv #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quotient
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  den_q;
    logic [CW-1:0] cnt_q;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        trial   = shifted - {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            quo_q <= '0;
            den_q <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem_q <= '0;
                quo_q <= dividend;
                den_q <= divisor;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                if (!trial[W]) begin
                    rem_q <= trial[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted[W-1:0];
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) done <= 1'b1;
            end
        end
    end

    assign quotient = quo_q;
endmodule

// File: rtl/thc_peak.sv
module thc_peak #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                upd,
    input  logic signed [W-1:0] val,
    output logic signed [W-1:0] peak
);
    localparam logic signed [W-1:0] FLOOR = {1'b1, {(W-1){1'b0}}};

    always_ff @(posedge clk) begin
        if (rst || clr)
            peak <= FLOOR;
        else if (upd && (val > peak))
            peak <= val;
    end
endmodule

// File: rtl/thc_temp_bank.sv
module thc_temp_bank #(
    parameter int NPTS = 4
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    start_i,
    input  logic [thc_pkg::DW-1:0]                  cal_w0_i,
    input  logic [thc_pkg::DW-1:0]                  cal_w1_i,
    input  logic [thc_pkg::DW-1:0]                  cal_w2_i,
    input  logic [$clog2(NPTS+1)-1:0]               npts_i,
    input  logic [NPTS-1:0][thc_pkg::DW-1:0]        raw_i,
    input  logic [NPTS-1:0][thc_pkg::IDX_W-1:0]     sidx_i,
    output logic signed [thc_pkg::DW-1:0]           temp_o,
    output logic [((NPTS>1)?$clog2(NPTS):1)-1:0]    temp_slot_o,
    output logic                                    temp_vld_o,
    output logic signed [thc_pkg::DW-1:0]           max_o,
    output logic                                    max_vld_o
);
    import thc_pkg::*;

    localparam int CNT_W  = $clog2(NPTS + 1);
    localparam int SLOT_W = (NPTS > 1) ? $clog2(NPTS) : 1;

    state_t                          state_q;
    cal_t                            cal_live;
    logic [GAIN_W-1:0]               gain_q;
    logic [REF_W-1:0]                ref_q;
    logic [NUM_TS-1:0][OFFS_W-1:0]   offs_q;
    logic [NPTS-1:0][RAW_W-1:0]      raw_q;
    logic [NPTS-1:0][IDX_W-1:0]      idx_q;
    logic [NPTS-1:0][OFFS_W-1:0]     pt_offs;
    logic [CNT_W-1:0]                npts_q;
    logic [SLOT_W-1:0]               slot_q;
    logic [DW-1:0]                   scale_q;

    logic                            accept;
    logic                            last_slot;
    logic                            div_go;
    logic                            div_done;
    logic [DW-1:0]                   div_num;
    logic [DW-1:0]                   div_den;
    logic [DW-1:0]                   div_quo;
    logic signed [DW-1:0]            cur_val;
    logic signed [DW-1:0]            peak;

    assign cal_live  = unpack_cal(cal_w0_i, cal_w1_i, cal_w2_i);
    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_slot = (CNT_W'(slot_q) + CNT_W'(1)) == npts_q;

    // divider operand steering: slope term first, gain term second
    always_comb begin
        div_go = accept || ((state_q == ST_DIV_SLOPE) && div_done);
        if (state_q == ST_IDLE) begin
            div_num = SCALE_NUM;
            div_den = SLOPE_BASE + DW'(cal_live.slope);
        end else begin
            div_num = div_quo;
            div_den = GAIN_BASE + DW'(gain_q);
        end
    end

    thc_rdiv #(.W(DW)) u_div (
        .clk      (clk),
        .rst      (rst),
        .go       (div_go),
        .dividend (div_num),
        .divisor  (div_den),
        .done     (div_done),
        .quotient (div_quo)
    );

    // per-slot offset lookup by sensor tag
    for (genvar g = 0; g < NPTS; g++) begin : g_slot_offs
        assign pt_offs[g] = (int'(idx_q[g]) < NUM_TS) ? offs_q[idx_q[g]] : DEF_OFFS;
    end

    assign cur_val = scrub(to_mdeg(scale_q, raw_q[slot_q], pt_offs[slot_q], ref_q));

    thc_peak #(.W(DW)) u_peak (
        .clk  (clk),
        .rst  (rst),
        .clr  (accept),
        .upd  (state_q == ST_CONV),
        .val  (cur_val),
        .peak (peak)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            gain_q      <= '0;
            ref_q       <= '0;
            offs_q      <= '0;
            raw_q       <= '0;
            idx_q       <= '0;
            npts_q      <= '0;
            slot_q      <= '0;
            scale_q     <= '0;
            temp_o      <= '0;
            temp_slot_o <= '0;
            temp_vld_o  <= 1'b0;
            max_o       <= '0;
            max_vld_o   <= 1'b0;
        end else begin
            temp_vld_o <= 1'b0;
            max_vld_o  <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        gain_q <= cal_live.gain;
                        ref_q  <= cal_live.ref_c;
                        offs_q <= cal_live.offs;
                        for (int k = 0; k < NPTS; k++) begin
                            raw_q[k] <= mask_raw(raw_i[k]);
                            idx_q[k] <= sidx_i[k];
                        end
                        npts_q  <= (int'(npts_i) > NPTS) ? CNT_W'(NPTS) : npts_i;
                        state_q <= ST_DIV_SLOPE;
                    end
                end
                ST_DIV_SLOPE: begin
                    if (div_done) state_q <= ST_DIV_GAIN;
                end
                ST_DIV_GAIN: begin
                    if (div_done) begin
                        scale_q <= div_quo;
                        slot_q  <= '0;
                        state_q <= (npts_q == '0) ? ST_FIN : ST_CONV;
                    end
                end
                ST_CONV: begin
                    temp_o      <= cur_val;
                    temp_slot_o <= slot_q;
                    temp_vld_o  <= 1'b1;
                    if (last_slot) state_q <= ST_FIN;
                    else           slot_q  <= slot_q + 1'b1;
                end
                ST_FIN: begin
                    max_o     <= peak;
                    max_vld_o <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/thc_temp_bank_chk.sv
module thc_temp_bank_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] temp,
    input logic        temp_vld,
    input logic [31:0] max_val,
    input logic        max_vld
);
    p_no_dual_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        !(temp_vld && max_vld));

    p_max_single_r8: assert property (@(posedge clk) disable iff (rst)
        max_vld |=> !max_vld);

    p_point_capped_r6: assert property (@(posedge clk) disable iff (rst)
        temp_vld |-> ($signed(temp) <= 32'sd200000));

    p_max_covers_last_r7: assert property (@(posedge clk) disable iff (rst)
        (max_vld && $past(temp_vld)) |-> ($signed(max_val) >= $signed($past(temp))));

    p_empty_bank_r7: assert property (@(posedge clk) disable iff (rst)
        (max_vld && !$past(temp_vld)) |-> (max_val == 32'h8000_0000));
endmodule

bind thc_temp_bank thc_temp_bank_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .temp     (temp_o),
    .temp_vld (temp_vld_o),
    .max_val  (max_o),
    .max_vld  (max_vld_o)
);

// File: tb/thc_temp_bank_tb_top.sv
`timescale 1ns/1ps
module thc_temp_bank_tb_top;

    typedef struct packed {
        logic             valid;
        logic [9:0]       ge;
        logic [5:0]       degc;
        logic [5:0]       os;
        logic [4:0][8:0]  vts;
        logic [2:0]       n;
        logic [3:0][11:0] raw;
        logic [3:0][2:0]  idx;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        // R5: defaults path, fields hold junk that must be ignored
        '{valid:1'b0, ge:10'd77, degc:6'd9, os:6'd50,
          vts:{9'd10, 9'd20, 9'd30, 9'd40, 9'd50}, n:3'd4,
          raw:{12'd3050, 12'd2900, 12'd3100, 12'd3000}, idx:{3'd3, 3'd2, 3'd1, 3'd0}},
        // R4: calibrated fields, tags out of slot order
        '{valid:1'b1, ge:10'd300, degc:6'd45, os:6'd20,
          vts:{9'd350, 9'd200, 9'd310, 9'd270, 9'd250}, n:3'd3,
          raw:{12'd0, 12'd3600, 12'd3300, 12'd2800}, idx:{3'd0, 3'd3, 3'd1, 3'd4}},
        // R6: raw 0 gives an implausible value
        '{valid:1'b1, ge:10'd1023, degc:6'd63, os:6'd63,
          vts:{9'd511, 9'd0, 9'd100, 9'd200, 9'd300}, n:3'd2,
          raw:{12'd0, 12'd0, 12'd3200, 12'd0}, idx:{3'd0, 3'd0, 3'd0, 3'd2}},
        // R7: single point below zero
        '{valid:1'b0, ge:10'd0, degc:6'd0, os:6'd0,
          vts:{9'd0, 9'd0, 9'd0, 9'd0, 9'd0}, n:3'd1,
          raw:{12'd0, 12'd0, 12'd0, 12'd4095}, idx:{3'd0, 3'd0, 3'd0, 3'd1}},
        // R7: empty bank
        '{valid:1'b1, ge:10'd5, degc:6'd5, os:6'd5,
          vts:{9'd5, 9'd5, 9'd5, 9'd5, 9'd5}, n:3'd0,
          raw:{12'd1, 12'd2, 12'd3, 12'd4}, idx:{3'd0, 3'd0, 3'd0, 3'd0}},
        // R9: tags beyond the sensor range
        '{valid:1'b1, ge:10'd100, degc:6'd30, os:6'd10,
          vts:{9'd400, 9'd400, 9'd400, 9'd400, 9'd400}, n:3'd2,
          raw:{12'd0, 12'd0, 12'd3000, 12'd2900}, idx:{3'd0, 3'd0, 3'd7, 3'd6}},
        // R7: count above four acts as four
        '{valid:1'b1, ge:10'd600, degc:6'd50, os:6'd3,
          vts:{9'd290, 9'd240, 9'd230, 9'd220, 9'd210}, n:3'd7,
          raw:{12'd2600, 12'd3900, 12'd2700, 12'd3400}, idx:{3'd4, 3'd3, 3'd2, 3'd5}}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic [31:0]       cal_w0_i = '0;
    logic [31:0]       cal_w1_i = '0;
    logic [31:0]       cal_w2_i = '0;
    logic [2:0]        npts_i = '0;
    logic [3:0][31:0]  raw_i = '0;
    logic [3:0][2:0]   sidx_i = '0;
    logic signed [31:0] temp_o;
    logic [1:0]        temp_slot_o;
    logic              temp_vld_o;
    logic signed [31:0] max_o;
    logic              max_vld_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    thc_temp_bank dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .cal_w0_i    (cal_w0_i),
        .cal_w1_i    (cal_w1_i),
        .cal_w2_i    (cal_w2_i),
        .npts_i      (npts_i),
        .raw_i       (raw_i),
        .sidx_i      (sidx_i),
        .temp_o      (temp_o),
        .temp_slot_o (temp_slot_o),
        .temp_vld_o  (temp_vld_o),
        .max_o       (max_o),
        .max_vld_o   (max_vld_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_temp(input vec_t v, input int s);
        int gain, degc, os, offs, q2, diff, t, res;
        longint q1;
        gain = v.valid ? int'(v.ge)   : 512;
        degc = v.valid ? int'(v.degc) : 40;
        os   = v.valid ? int'(v.os)   : 0;
        if (v.idx[s] > 3'd4)  offs = 260;
        else if (!v.valid)    offs = 260;
        else                  offs = int'(v.vts[v.idx[s]]);
        q1   = 64'd1627604160 / longint'(165 + os);
        q2   = int'(q1 / longint'(10000 + gain));
        diff = int'(v.raw[s]) - offs - 3350;
        t    = q2 * diff;
        t    = t >>> 3;
        res  = degc * 500 - t;
        if (res > 200000) res = 0;
        return res;
    endfunction

    task automatic drive_vec(input vec_t v);
        cal_w0_i = {v.os, v.vts[0], v.vts[1], 1'b0, v.degc, v.valid};
        cal_w1_i = {v.ge, 13'd0, v.vts[2]};
        cal_w2_i = {v.vts[3], v.vts[4], 14'd0};
        npts_i   = v.n;
        for (int k = 0; k < 4; k++) begin
            raw_i[k]  = {20'hA5A5A, v.raw[k]};   // R2: junk in upper bits
            sidx_i[k] = v.idx[k];
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke, input string tag);
        int eff_n, seen, cyc, last_t, emax;
        bit got_max;
        eff_n = (v.n > 3'd4) ? 4 : int'(v.n);
        emax = 32'h8000_0000;
        for (int s = 0; s < eff_n; s++)
            if (exp_temp(v, s) > emax) emax = exp_temp(v, s);
        @(negedge clk);
        drive_vec(v);
        start_i = 1'b1;
        seen = 0; cyc = 0; last_t = -100; got_max = 1'b0;
        while (!got_max && cyc < 500) begin
            @(negedge clk);
            cyc++;
            start_i = 1'b0;
            if (temp_vld_o) begin
                check(int'(temp_slot_o) == seen, {tag, " R8 slot order"}, int'(temp_slot_o), seen);
                check(temp_o == exp_temp(v, seen), {tag, " R2 R3 point value"}, temp_o, exp_temp(v, seen));
                if (seen > 0) check(cyc == last_t + 1, {tag, " R8 consecutive points"}, cyc, last_t + 1);
                seen++;
                last_t = cyc;
            end
            if (max_vld_o) begin
                got_max = 1'b1;
                check(max_o == emax, {tag, " R7 bank maximum"}, max_o, emax);
                if (eff_n > 0) check(cyc == last_t + 1, {tag, " R8 max after last point"}, cyc, last_t + 1);
            end
            if (poke && cyc == 5) begin
                // R10: new start and new inputs while busy
                cal_w0_i = ~cal_w0_i;
                cal_w1_i = ~cal_w1_i;
                cal_w2_i = ~cal_w2_i;
                raw_i    = '1;
                npts_i   = 3'd1;
                start_i  = 1'b1;
            end
        end
        check(got_max, {tag, " R8 max pulse seen"}, int'(got_max), 1);
        check(seen == eff_n, {tag, " R7 R8 point count"}, seen, eff_n);
    endtask

    task automatic expect_quiet(input int cycles, input string tag);
        int pulses;
        pulses = 0;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            start_i = 1'b0;
            if (temp_vld_o || max_vld_o) pulses++;
        end
        check(pulses == 0, {tag, " no further pulses"}, pulses, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(!temp_vld_o, "R1 temp_vld after reset", int'(temp_vld_o), 0);
        check(!max_vld_o,  "R1 max_vld after reset",  int'(max_vld_o), 0);
        check(temp_o == 0, "R1 temp_o after reset",   temp_o, 0);
        check(max_o == 0,  "R1 max_o after reset",    max_o, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b0, $sformatf("vec%0d", i));
            repeat (3) @(negedge clk);
        end

        // R10: start while busy is ignored, inputs changed mid-run
        run_vec(VECS[1], 1'b1, "busy R10");
        expect_quiet(150, "R10 ignored start");

        // R1: reset in the middle of a conversion
        @(negedge clk);
        drive_vec(VECS[0]);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        expect_quiet(150, "R1 aborted run");
        check(temp_o == 0, "R1 temp_o after mid-run reset", temp_o, 0);
        check(max_o == 0,  "R1 max_o after mid-run reset",  max_o, 0);

        // recovery after reset, R9 and R3 again
        run_vec(VECS[5], 1'b0, "post-reset R9");

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule